// File: doc/BRIEF.md
# Shared-cache sharer directory built from L1 tag copies

This block sits beside one bank of a shared second-level cache and decides which private first-level data caches must drop a line when any core stores to it. It does not keep sharer bits in the second-level lines. Instead it holds one copy of each core's L1 data-cache tag array for the sets that map to this bank. The first-level caches are write-through and allocate only on read misses. Every store therefore reaches this bank, and only read fills create L1 copies.

A read fill reports the core, the L1 way and the line address, and the block records the tag in that core's copy. An eviction notice names the core, set and way, and the block clears that entry. When a store is accepted, all cores' copies are searched at the store's set in the same cycle. Each core other than the writer whose copy holds the tag receives an invalidate, carrying the set and the way to drop. The replicated entry is cleared at once. The store is reported complete only after every invalidate it raised has been acknowledged. One instance serves each bank, and the bank-select bits of the line address are not stored or compared.

Top module: `l1dir_top`

## Requirements
- R1: After reset no invalidate is raised, `st_ready` is 1, `st_done` is 0, and a store to any line raises no invalidate.
- R2: A read fill from core c to way w records the line. A later store to that line by another core raises `inv_valid[c]`, with `inv_set` equal to the store's set field and `inv_way` slice c equal to w.
- R3: The writing core never receives an invalidate for its own store, and its replicated entry stays valid, so a later store by another core to that line invalidates the writer.
- R4: In the cycle after a store is accepted, `inv_valid` is asserted for exactly the set of non-writing cores whose copies hold the line, all at once.
- R5: An entry is cleared when its invalidate is raised, so a second store to the same line raises no invalidate for that core unless it fills again.
- R6: An eviction notice for core c, set s, way w clears that entry, and a later store to the line it held does not invalidate core c.
- R7: Line address layout: bits [1:0] select the bank and are ignored, bits [4:2] are the L1 set, and bits [11:5] are the stored tag. Addresses that differ only in bits [1:0] match.
- R8: `inv_valid[c]` stays high until the cycle in which `inv_ack[c]` is high. An acknowledge on a core whose invalidate is not raised has no effect.
- R9: `st_done` is high for exactly one cycle, once no invalidate remains outstanding. That is the cycle after the last acknowledge, or the cycle after acceptance if there were no sharers. `st_ready` is low from acceptance until the cycle after `st_done`.
- R10: When a fill and an eviction name the same core, set and way in one cycle, the fill takes effect and the entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | L1 read fill notice |
| fill_core | input | 2 | Core that filled |
| fill_way | input | 1 | L1 way written by the fill |
| fill_addr | input | 12 | Line address of the fill |
| evict_valid | input | 1 | L1 eviction notice |
| evict_core | input | 2 | Core that evicted |
| evict_set | input | 3 | L1 set of the evicted line |
| evict_way | input | 1 | L1 way of the evicted line |
| st_valid | input | 1 | Store request |
| st_core | input | 2 | Writing core |
| st_addr | input | 12 | Line address of the store |
| st_ready | output | 1 | Directory can accept a store this cycle |
| st_done | output | 1 | Store complete, all invalidates acknowledged |
| inv_valid | output | 4 | Per-core invalidate request |
| inv_set | output | 3 | L1 set to invalidate |
| inv_way | output | 4 | Per-core L1 way to invalidate, 1 bit per core |
| inv_ack | input | 4 | Per-core invalidate acknowledge |

## Verification
A corrupted replicated entry cannot be seen directly. It shows up only at the next store to that set. A stale valid bit produces an extra `inv_valid` bit, or a wrong `inv_way`, one cycle after acceptance. A lost entry produces a missing invalidate in that same cycle. Errors in the acknowledge bookkeeping show as an `inv_valid` bit that drops early or never drops, and as `st_done` arriving a cycle early or late. The bench therefore runs many random fills, evictions and stores against a reference copy of all tag arrays, and it compares every cycle of every store's invalidate phase.

// File: rtl/l1dir_pkg.sv
package l1dir_pkg;

    // Store-processing phases of the directory
    typedef enum logic {
        DIR_IDLE = 1'b0,
        DIR_WAIT = 1'b1
    } dir_state_e;

    // Default geometry of one bank's directory
    localparam int DEF_CORES  = 4;
    localparam int DEF_SETS   = 8;
    localparam int DEF_WAYS   = 2;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_BANK_W = 2;

    // Width of an index into n items, at least 1
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/l1dir_tag_copy.sv
module l1dir_tag_copy
    import l1dir_pkg::*;
#(
    parameter int SETS  = DEF_SETS,
    parameter int WAYS  = DEF_WAYS,
    parameter int TAG_W = 7,
    localparam int SET_W = idx_w(SETS),
    localparam int WAY_W = idx_w(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             ev_en,
    input  logic [SET_W-1:0] ev_set,
    input  logic [WAY_W-1:0] ev_way,
    input  logic             kill_en,
    input  logic [SET_W-1:0] kill_set,
    input  logic [WAY_W-1:0] kill_way,
    input  logic [SET_W-1:0] srch_set,
    input  logic [TAG_W-1:0] srch_tag,
    output logic             srch_hit,
    output logic [WAY_W-1:0] srch_way
);

    logic [SETS-1:0][WAYS-1:0] vld_q;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];

    // Clears first, fill last: a same-cycle fill wins
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (ev_en)   vld_q[ev_set][ev_way]     <= 1'b0;
            if (kill_en) vld_q[kill_set][kill_way] <= 1'b0;
            if (wr_en)   vld_q[wr_set][wr_way]     <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    // Lowest matching way wins
    always_comb begin
        srch_hit = 1'b0;
        srch_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_q[srch_set][w] && (tag_q[srch_set][w] == srch_tag)) begin
                srch_hit = 1'b1;
                srch_way = WAY_W'(w);
            end
        end
    end

    // R2
    fill_records_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_set)][$past(wr_way)]);

    // R6
    evict_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_en && !(wr_en && wr_set == ev_set && wr_way == ev_way))
        |=> !vld_q[$past(ev_set)][$past(ev_way)]);

    // R5
    kill_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (kill_en && !(wr_en && wr_set == kill_set && wr_way == kill_way))
        |=> !vld_q[$past(kill_set)][$past(kill_way)]);

endmodule

// File: rtl/l1dir_ctrl.sv
module l1dir_ctrl
    import l1dir_pkg::*;
#(
    parameter int CORES = DEF_CORES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [CORES-1:0] match,
    input  logic [CORES-1:0] inv_ack,
    output logic             st_ready,
    output logic             st_accept,
    output logic             st_done,
    output logic [CORES-1:0] pend
);

    dir_state_e       state_q;
    logic [CORES-1:0] pend_q;

    assign st_ready  = (state_q == DIR_IDLE);
    assign st_accept = st_valid && st_ready;
    assign st_done   = (state_q == DIR_WAIT) && (pend_q == '0);
    assign pend      = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIR_IDLE;
            pend_q  <= '0;
        end else begin
            unique case (state_q)
                DIR_IDLE: begin
                    if (st_accept) begin
                        pend_q  <= match;
                        state_q <= DIR_WAIT;
                    end
                end
                DIR_WAIT: begin
                    if (pend_q == '0) state_q <= DIR_IDLE;
                    else              pend_q  <= pend_q & ~inv_ack;
                end
                default: state_q <= DIR_IDLE;
            endcase
        end
    end

    // R8
    for (genvar c = 0; c < CORES; c++) begin : g_hold
        inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_q[c] && !inv_ack[c]) |=> pend_q[c]);
    end

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        st_done |-> (pend_q == '0) && !st_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_done |=> !st_done && st_ready);

    // R4
    inv_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |-> !st_ready);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        st_accept |=> !st_ready);

endmodule

// File: rtl/l1dir_top.sv
module l1dir_top
    import l1dir_pkg::*;
#(
    parameter int CORES  = DEF_CORES,
    parameter int SETS   = DEF_SETS,
    parameter int WAYS   = DEF_WAYS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BANK_W = DEF_BANK_W,
    localparam int CORE_W = idx_w(CORES),
    localparam int SET_W  = idx_w(SETS),
    localparam int WAY_W  = idx_w(WAYS),
    localparam int TAG_LO = BANK_W + SET_W,
    localparam int TAG_W  = ADDR_W - TAG_LO
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fill_valid,
    input  logic [CORE_W-1:0]      fill_core,
    input  logic [WAY_W-1:0]       fill_way,
    input  logic [ADDR_W-1:0]      fill_addr,
    input  logic                   evict_valid,
    input  logic [CORE_W-1:0]      evict_core,
    input  logic [SET_W-1:0]       evict_set,
    input  logic [WAY_W-1:0]       evict_way,
    input  logic                   st_valid,
    input  logic [CORE_W-1:0]      st_core,
    input  logic [ADDR_W-1:0]      st_addr,
    output logic                   st_ready,
    output logic                   st_done,
    output logic [CORES-1:0]       inv_valid,
    output logic [SET_W-1:0]       inv_set,
    output logic [CORES*WAY_W-1:0] inv_way,
    input  logic [CORES-1:0]       inv_ack
);

    // Bank bits sit at the bottom and are neither stored nor compared
    logic [SET_W-1:0] fill_set, st_set;
    logic [TAG_W-1:0] fill_tag, st_tag;

    assign fill_set = fill_addr[BANK_W +: SET_W];
    assign fill_tag = fill_addr[ADDR_W-1:TAG_LO];
    assign st_set   = st_addr[BANK_W +: SET_W];
    assign st_tag   = st_addr[ADDR_W-1:TAG_LO];

    logic             st_accept;
    logic [CORES-1:0] match;
    logic [WAY_W-1:0] hit_way [CORES];

    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic hit;

        l1dir_tag_copy #(
            .SETS  (SETS),
            .WAYS  (WAYS),
            .TAG_W (TAG_W)
        ) u_copy (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (fill_valid && (fill_core == CORE_W'(c))),
            .wr_set   (fill_set),
            .wr_way   (fill_way),
            .wr_tag   (fill_tag),
            .ev_en    (evict_valid && (evict_core == CORE_W'(c))),
            .ev_set   (evict_set),
            .ev_way   (evict_way),
            .kill_en  (st_accept && match[c]),
            .kill_set (st_set),
            .kill_way (hit_way[c]),
            .srch_set (st_set),
            .srch_tag (st_tag),
            .srch_hit (hit),
            .srch_way (hit_way[c])
        );

        // The writer keeps its own copy
        assign match[c] = hit && (st_core != CORE_W'(c));

        logic [WAY_W-1:0] way_q;
        always_ff @(posedge clk) begin
            if (rst)            way_q <= '0;
            else if (st_accept) way_q <= hit_way[c];
        end
        assign inv_way[c*WAY_W +: WAY_W] = way_q;
    end

    logic [SET_W-1:0] set_q;
    always_ff @(posedge clk) begin
        if (rst)            set_q <= '0;
        else if (st_accept) set_q <= st_set;
    end
    assign inv_set = set_q;

    l1dir_ctrl #(
        .CORES (CORES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .match     (match),
        .inv_ack   (inv_ack),
        .st_ready  (st_ready),
        .st_accept (st_accept),
        .st_done   (st_done),
        .pend      (inv_valid)
    );

    // R3
    writer_spared_chk: assert property (@(posedge clk) disable iff (rst)
        st_accept |=> !inv_valid[$past(st_core)]);

    // R4
    inv_launch_chk: assert property (@(posedge clk) disable iff (rst)
        st_accept |=> (inv_valid == $past(match)));

endmodule

// File: tb/l1dir_top_tb.sv
module l1dir_top_tb;

    localparam int NC = 4, NS = 8, NW = 2, AW = 12;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          fill_valid = 0, evict_valid = 0, st_valid = 0;
    logic [1:0]    fill_core = 0, evict_core = 0, st_core = 0;
    logic          fill_way = 0, evict_way = 0;
    logic [2:0]    evict_set = 0;
    logic [AW-1:0] fill_addr = 0, st_addr = 0;
    logic          st_ready, st_done;
    logic [NC-1:0] inv_valid, inv_ack = 0;
    logic [2:0]    inv_set;
    logic [NC-1:0] inv_way;

    l1dir_top u_dut (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_core(fill_core), .fill_way(fill_way), .fill_addr(fill_addr),
        .evict_valid(evict_valid), .evict_core(evict_core), .evict_set(evict_set), .evict_way(evict_way),
        .st_valid(st_valid), .st_core(st_core), .st_addr(st_addr),
        .st_ready(st_ready), .st_done(st_done),
        .inv_valid(inv_valid), .inv_set(inv_set), .inv_way(inv_way), .inv_ack(inv_ack)
    );

    int total = 0, bad = 0;
    bit mv [NC][NS][NW];
    logic [6:0] mt [NC][NS][NW];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int set, input int bank);
        return {7'(tag), 3'(set), 2'(bank)};
    endfunction

    task automatic do_fill(input int core, input int way, input logic [AW-1:0] a);
        fill_valid = 1; fill_core = 2'(core); fill_way = way[0]; fill_addr = a;
        @(negedge clk);
        fill_valid = 0;
        mv[core][a[4:2]][way] = 1; mt[core][a[4:2]][way] = a[11:5];
    endtask

    task automatic do_evict(input int core, input int set, input int way);
        evict_valid = 1; evict_core = 2'(core); evict_set = 3'(set); evict_way = way[0];
        @(negedge clk);
        evict_valid = 0;
        mv[core][set][way] = 0;
    endtask

    // Store with expected invalidates from the reference arrays
    task automatic do_store(input int core, input logic [AW-1:0] a, input string req,
                            input bit junk_acks);
        logic [NC-1:0] ep = 0, ack;
        logic [NC-1:0] ew = 0;
        int set = a[4:2];
        for (int c = 0; c < NC; c++) begin
            if (c != core) begin
                for (int w = NW - 1; w >= 0; w--)
                    if (mv[c][set][w] && mt[c][set][w] == a[11:5]) begin ep[c] = 1; ew[c] = w[0]; end
                if (ep[c]) mv[c][set][ew[c]] = 0;
            end
        end
        chk(st_ready == 1, "R9 ready idle", st_ready, 1);
        st_valid = 1; st_core = 2'(core); st_addr = a;
        @(negedge clk);
        st_valid = 0;
        chk(inv_valid == ep, {req, " R4 inv set of sharers"}, inv_valid, ep);
        chk(inv_valid[core] == 0, "R3 writer spared", inv_valid, ep);
        for (int it = 0; it < 40; it++) begin
            if (ep == 0) begin
                chk(st_done == 1, "R9 done", st_done, 1);
                chk(inv_valid == 0, "R9 no inv at done", inv_valid, 0);
                break;
            end
            chk(inv_valid == ep, "R8 held until ack", inv_valid, ep);
            chk(st_done == 0 && st_ready == 0, "R9 busy", {st_done, st_ready}, 0);
            chk(inv_set == 3'(set), "R2 inv_set", inv_set, set);
            for (int c = 0; c < NC; c++)
                if (ep[c]) chk(inv_way[c] == ew[c], "R2 inv_way", inv_way[c], ew[c]);
            ack = 4'($urandom) & ep;
            if (it > 8) ack = ep;
            if (junk_acks) ack = ack | (4'($urandom) & ~ep);
            inv_ack = ack;
            @(negedge clk);
            inv_ack = 0;
            ep = ep & ~ack;
        end
        @(negedge clk);
        chk(st_ready == 1 && st_done == 0, "R9 back to idle", {st_ready, st_done}, 2);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1));
        foreach (mv[c, s, w]) begin mv[c][s][w] = 0; mt[c][s][w] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(inv_valid == 0 && st_ready == 1 && st_done == 0, "R1 reset outputs",
            {inv_valid, st_ready, st_done}, 4'b0 << 2 | 2);
        do_store(1, mk(5, 3, 0), "R1 empty", 0);

        // R2 / R3 / R5 directed
        do_fill(0, 1, mk(9, 2, 0));
        do_fill(1, 0, mk(9, 2, 0));
        do_store(0, mk(9, 2, 0), "R2 R3 core1 only", 0);
        do_store(2, mk(9, 2, 0), "R3 writer later hit", 0);
        do_store(2, mk(9, 2, 0), "R5 second store clean", 0);

        // R6 eviction
        do_fill(3, 1, mk(20, 6, 0));
        do_evict(3, 6, 1);
        do_store(0, mk(20, 6, 0), "R6 evicted", 0);

        // R7 bank bits ignored
        do_fill(2, 0, mk(33, 5, 0));
        do_store(1, mk(33, 5, 3), "R7 other bank bits", 0);
        do_fill(2, 0, mk(33, 5, 0));
        do_store(1, mk(34, 5, 0), "R7 tag differs", 0);

        // R10 fill and evict same entry same cycle
        fill_valid = 1; fill_core = 1; fill_way = 1; fill_addr = mk(44, 0, 0);
        evict_valid = 1; evict_core = 1; evict_set = 0; evict_way = 1;
        @(negedge clk);
        fill_valid = 0; evict_valid = 0;
        mv[1][0][1] = 1; mt[1][0][1] = 44;
        do_store(3, mk(44, 0, 0), "R10 fill wins", 0);

        // R4 all cores share, R8 junk acks
        for (int c = 0; c < NC; c++) do_fill(c, c % 2, mk(50, 7, 0));
        do_store(0, mk(50, 7, 1), "R4 three sharers", 1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            int c = $urandom_range(0, NC - 1);
            int s = $urandom_range(0, 1);
            int w = $urandom_range(0, NW - 1);
            int t = $urandom_range(0, 2);
            if (op < 5)      do_fill(c, w, mk(t, s, $urandom_range(0, 3)));
            else if (op < 7) do_evict(c, s, w);
            else             do_store(c, mk(t, s, $urandom_range(0, 3)), "R4 random", op == 9);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule